// File: doc/BRIEF.md
# Interleaved Word Read Scheduler for a Multi-Bank DRAM Channel

This block sits in front of one DRAM channel whose banks share a single 64-bit data bus. It accepts random single-word read requests, each naming its own bank, row and column, and turns them into activate, read and precharge commands. Each bank keeps its own open row, so eight banks may hold eight unrelated rows at once. Preparation of different banks overlaps in time, so words from different banks come back on consecutive bus cycles.

One request slot per bank holds the address and tag of the waiting read. A per-bank timer enforces the activate-to-read and precharge-to-activate gaps. A row hit goes straight to the read; a row miss on an idle bank activates first; a row conflict precharges, then activates. Rows stay open after the read. The command bus carries one command per cycle. When several banks are ready in the same cycle, the bank whose request has waited longest wins. The read word returns a fixed number of cycles after its read command. The block pairs that word with the stored tag, so callers can match responses that return out of request order.

The request side is a valid/ready stream. A request waits, with all fields held stable, while `req_ready` is low. `req_ready` depends only on whether the addressed bank still has a request in progress. The response side has no ready input: the memory returns data at a fixed latency, so the consumer must take each response in the cycle it appears.

Top module: `sg_read_sched`

## Requirements
- R1: `req_ready` is high exactly when the bank selected by `req_bank` holds no unfinished request, whatever the value of `req_valid`; a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and requests to other banks are accepted while one bank is busy.
- R2: A request to a bank with no open row produces an activate (`cmd_op` = 1) in the second cycle after acceptance, and the read (`cmd_op` = 2) follows exactly T_RCD cycles after that activate when the command bus is free.
- R3: A request whose row equals the bank's open row issues no activate or precharge; its read appears in the second cycle after acceptance when uncontended.
- R4: A request to a different row than the one open in its bank issues a precharge (`cmd_op` = 3) in the second cycle after acceptance, an activate T_RP cycles later and the read T_RCD cycles after that; no activate ever reaches an open bank and no precharge reaches a closed one.
- R5: A row stays open after its read, and each bank holds its own open row independently of the others.
- R6: At most one command is issued per cycle; reads that hit open rows in different banks and are accepted on consecutive cycles produce responses on consecutive cycles.
- R7: When more than one bank is ready to issue in the same cycle, the bank whose request was accepted earliest is served, and the others wait one cycle or more.
- R8: Each read command yields exactly one response, carrying the request's tag and the word driven on `dram_rdata`. `rsp_valid` is high T_CL+1 cycles after the cycle in which the read command is visible.
- R9: After reset no row is open, `cmd_valid` and `rsp_valid` are low and `req_ready` is high for every bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Addressed bank can take a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Word index within the row |
| req_tag | input | TAG_W | Caller's identifier for the request |
| cmd_valid | output | 1 | Command present on the command bus |
| cmd_op | output | 2 | 1 activate, 2 read, 3 precharge |
| cmd_bank | output | BANK_W | Bank the command targets |
| cmd_row | output | ROW_W | Row for activate |
| cmd_col | output | COL_W | Column for read |
| dram_rvalid | input | 1 | Memory is driving a read word |
| dram_rdata | input | DATA_W | Read word from the shared bus |
| rsp_valid | output | 1 | Response present |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_data | output | DATA_W | Returned word |

## Verification
Isolated requests to an idle bank, to its open row and to a conflicting row tell the three command paths apart by the exact cycle of the read. A volley of open-row hits to four banks on consecutive cycles separates true bank interleaving from a scheduler that serialises whole accesses. A precharge-then-activate timed to collide with a fresh activate in another bank shows the oldest-first choice by which read slips one cycle. A long run of random banks and a few rows per bank mixes hits and conflicts under contention. A memory model in the bench checks every command against the open-row state and the timing gaps, and checks every response's data, tag and latency.

// File: rtl/sg_sched_pkg.sv
package sg_sched_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ACT  = 2'd1,
    OP_RD   = 2'd2,
    OP_PRE  = 2'd3
  } dram_op_e;

  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_NEED_PRE,
    SLOT_NEED_ACT,
    SLOT_NEED_RD
  } slot_state_e;
endpackage

// File: rtl/sg_bank_slot.sv
module sg_bank_slot
  import sg_sched_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 7,
  parameter int TAG_W = 6,
  parameter int AGE_W = 6,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             grant,
  output logic             busy,
  output logic             want,
  output dram_op_e         op,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [AGE_W-1:0] age_o
);
  localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  slot_state_e      st;
  logic             open_q;
  logic [ROW_W-1:0] open_row;
  logic [ROW_W-1:0] p_row;
  logic [COL_W-1:0] p_col;
  logic [TAG_W-1:0] p_tag;
  logic [CNT_W-1:0] gap_cnt;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SLOT_IDLE;
      open_q   <= 1'b0;
      open_row <= '0;
      p_row    <= '0;
      p_col    <= '0;
      p_tag    <= '0;
    end else if (accept) begin
      p_row <= in_row;
      p_col <= in_col;
      p_tag <= in_tag;
      if (!open_q)                st <= SLOT_NEED_ACT;
      else if (open_row == in_row) st <= SLOT_NEED_RD;
      else                        st <= SLOT_NEED_PRE;
    end else if (grant) begin
      case (st)
        SLOT_NEED_PRE: begin
          st     <= SLOT_NEED_ACT;
          open_q <= 1'b0;
        end
        SLOT_NEED_ACT: begin
          st       <= SLOT_NEED_RD;
          open_q   <= 1'b1;
          open_row <= p_row;
        end
        SLOT_NEED_RD: st <= SLOT_IDLE;
        default:      st <= SLOT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              gap_cnt <= '0;
    else if (grant && st == SLOT_NEED_PRE)   gap_cnt <= CNT_W'(T_RP - 1);
    else if (grant && st == SLOT_NEED_ACT)   gap_cnt <= CNT_W'(T_RCD - 1);
    else if (gap_cnt != '0)                  gap_cnt <= gap_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accept)                           age_q <= '0;
    else if (st != SLOT_IDLE && age_q != AGE_MAX)   age_q <= age_q + 1'b1;
  end

  always_comb begin
    case (st)
      SLOT_NEED_PRE: op = OP_PRE;
      SLOT_NEED_ACT: op = OP_ACT;
      SLOT_NEED_RD:  op = OP_RD;
      default:       op = OP_NONE;
    endcase
  end

  assign busy  = (st != SLOT_IDLE);
  assign want  = busy && (gap_cnt == '0);
  assign row_o = p_row;
  assign col_o = p_col;
  assign tag_o = p_tag;
  assign age_o = age_q;

  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && op == OP_ACT) |-> !open_q); // R4
  AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && op == OP_PRE) |-> open_q); // R4
  AST_RD_ON_OWN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && op == OP_RD) |-> (open_q && open_row == p_row)); // R3
  AST_ACCEPT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !grant); // R1
  AST_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && op == OP_RD) |=> open_q); // R5
endmodule

// File: rtl/sg_oldest_pick.sv
module sg_oldest_pick #(
  parameter int N     = 8,
  parameter int AGE_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              want,
  input  logic [N-1:0][AGE_W-1:0]   age,
  output logic [N-1:0]              grant
);
  logic [AGE_W-1:0] best_age;
  logic             found;

  always_comb begin
    grant    = '0;
    best_age = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (want[i] && (!found || age[i] > best_age)) begin
        grant    = '0;
        grant[i] = 1'b1;
        best_age = age[i];
        found    = 1'b1;
      end
    end
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_GRANT_WANTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~want) == '0)); // R7
  AST_NO_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (want != '0) |-> (grant != '0)); // R7
endmodule

// File: rtl/sg_tag_delay.sv
module sg_tag_delay #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag
);
  logic [DEPTH-1:0] v_q;
  logic [TAG_W-1:0] t_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      t_q[0] <= '0;
    end else begin
      v_q[0] <= in_valid;
      t_q[0] <= in_tag;
    end
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        t_q[s] <= '0;
      end else begin
        v_q[s] <= v_q[s-1];
        t_q[s] <= t_q[s-1];
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_tag   = t_q[DEPTH-1];
endmodule

// File: rtl/sg_read_sched.sv
module sg_read_sched
  import sg_sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 7,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 64,
  parameter int AGE_W     = 6,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_CL      = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  input  logic              dram_rvalid,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  logic [NUM_BANKS-1:0]             busy, want, grant, accept;
  dram_op_e                         op   [NUM_BANKS];
  logic [ROW_W-1:0]                 rows [NUM_BANKS];
  logic [COL_W-1:0]                 cols [NUM_BANKS];
  logic [TAG_W-1:0]                 tags [NUM_BANKS];
  logic [NUM_BANKS-1:0][AGE_W-1:0]  ages;

  assign req_ready = !busy[req_bank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign accept[b] = req_valid && req_ready && (req_bank == BANK_W'(b));
    sg_bank_slot #(
      .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W), .AGE_W(AGE_W),
      .T_RCD(T_RCD), .T_RP(T_RP)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .accept(accept[b]),
      .in_row(req_row), .in_col(req_col), .in_tag(req_tag),
      .grant(grant[b]), .busy(busy[b]), .want(want[b]), .op(op[b]),
      .row_o(rows[b]), .col_o(cols[b]), .tag_o(tags[b]), .age_o(ages[b])
    );
  end

  sg_oldest_pick #(.N(NUM_BANKS), .AGE_W(AGE_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .want(want), .age(ages), .grant(grant)
  );

  logic [BANK_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (grant[i]) sel = BANK_W'(i);
  end

  logic issue_rd;
  assign issue_rd = (grant != '0) && (op[sel] == OP_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
    end else begin
      cmd_valid <= (grant != '0);
      cmd_op    <= (grant != '0) ? op[sel] : OP_NONE;
      cmd_bank  <= sel;
      cmd_row   <= rows[sel];
      cmd_col   <= cols[sel];
    end
  end

  logic             pipe_valid;
  logic [TAG_W-1:0] pipe_tag;

  sg_tag_delay #(.TAG_W(TAG_W), .DEPTH(T_CL + 1)) u_tags (
    .clk(clk), .rst_n(rst_n), .in_valid(issue_rd), .in_tag(tags[sel]),
    .out_valid(pipe_valid), .out_tag(pipe_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= pipe_valid;
      rsp_tag   <= pipe_tag;
      rsp_data  <= dram_rdata;
    end
  end

  AST_DATA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dram_rvalid == pipe_valid); // R8
  AST_CMD_HAS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != OP_NONE)); // R6
  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept)); // R1
endmodule

// File: tb/sim_sg_read_sched.sv
module sim_sg_read_sched;
  localparam int NB = 8, ROW_W = 14, COL_W = 7, TAG_W = 6, DATA_W = 64;
  localparam int T_RCD = 3, T_RP = 3, T_CL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [2:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic dram_rvalid = 1'b0;
  logic [DATA_W-1:0] dram_rdata = '0;
  logic rsp_valid;
  logic [TAG_W-1:0] rsp_tag;
  logic [DATA_W-1:0] rsp_data;

  always #10 clk = ~clk;

  sg_read_sched #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
    .DATA_W(DATA_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_CL(T_CL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_tag(req_tag),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .dram_rvalid(dram_rvalid),
    .dram_rdata(dram_rdata), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_data(rsp_data));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] word_of(int b, int r, int c);
    return {8'h5A, 8'(b), 16'(r), 16'(c), 16'hBEEF};
  endfunction

  // request records (driver writes), completion records (monitor writes)
  int t_bank[64], t_row[64], t_col[64], t_acc[64], t_set[64];
  int t_rd[64], t_rsp[64], t_done[64];
  int pend_tag[NB];
  int next_tag = 0;
  int d_checks = 0, d_fails = 0, m_checks = 0, m_fails = 0, wd_fail = 0;

  // memory model state
  bit b_open[NB];
  int b_row[NB], b_pre[NB], b_act[NB];
  bit due_v[16];
  logic [63:0] due_d[16];

  initial begin
    for (int i = 0; i < NB; i++) begin b_pre[i] = -100; b_act[i] = -100; end
    for (int i = 0; i < 64; i++) begin t_set[i] = 0; t_done[i] = 0; end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      dram_rvalid = 1'b0;
    end else begin
      dram_rvalid = due_v[cyc % 16];
      dram_rdata  = due_d[cyc % 16];
      due_v[cyc % 16] = 1'b0;
      if (cmd_valid) begin
        m_checks++;
        case (cmd_op)
          2'd1: begin
            if (b_open[cmd_bank] || cyc - b_pre[cmd_bank] < T_RP) begin
              m_fails++;
              $display("FAIL R4 activate bank %0d open=%0d gap=%0d expected closed, gap>=%0d",
                       cmd_bank, b_open[cmd_bank], cyc - b_pre[cmd_bank], T_RP);
            end
            b_open[cmd_bank] = 1'b1; b_row[cmd_bank] = int'(cmd_row); b_act[cmd_bank] = cyc;
          end
          2'd2: begin
            int tg;
            tg = pend_tag[cmd_bank];
            if (!b_open[cmd_bank] || cyc - b_act[cmd_bank] < T_RCD ||
                b_row[cmd_bank] != t_row[tg] || int'(cmd_col) != t_col[tg]) begin
              m_fails++;
              $display("FAIL R2 read bank %0d row=%0d col=%0d gap=%0d expected row=%0d col=%0d gap>=%0d",
                       cmd_bank, b_row[cmd_bank], cmd_col, cyc - b_act[cmd_bank],
                       t_row[tg], t_col[tg], T_RCD);
            end
            t_rd[tg] = cyc;
            due_v[(cyc + T_CL) % 16] = 1'b1;
            due_d[(cyc + T_CL) % 16] = word_of(cmd_bank, b_row[cmd_bank], int'(cmd_col));
          end
          2'd3: begin
            if (!b_open[cmd_bank]) begin
              m_fails++;
              $display("FAIL R4 precharge of closed bank %0d actual=0 expected=1", cmd_bank);
            end
            b_open[cmd_bank] = 1'b0; b_pre[cmd_bank] = cyc;
          end
          default: begin
            m_fails++;
            $display("FAIL R6 command with op actual=%0d expected=1..3", cmd_op);
          end
        endcase
      end
      if (rsp_valid) begin
        int tg;
        tg = int'(rsp_tag);
        m_checks++;
        if (t_set[tg] <= t_done[tg]) begin
          m_fails++;
          $display("FAIL R8 response for tag %0d actual=unrequested expected=outstanding", tg);
        end else if (rsp_data != word_of(t_bank[tg], t_row[tg], t_col[tg]) ||
                     cyc != t_rd[tg] + T_CL + 1) begin
          m_fails++;
          $display("FAIL R8 tag %0d data=%h cycle=%0d expected data=%h cycle=%0d", tg, rsp_data,
                   cyc, word_of(t_bank[tg], t_row[tg], t_col[tg]), t_rd[tg] + T_CL + 1);
        end
        t_rsp[tg] = cyc;
        t_done[tg]++;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    d_checks++;
    if (!ok) begin
      d_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int b, input int r, input int c, output int acc, output int tg);
    tg = next_tag % 64;
    next_tag++;
    req_valid = 1'b1; req_bank = 3'(b); req_row = ROW_W'(r);
    req_col = COL_W'(c); req_tag = TAG_W'(tg);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc = cyc;
    t_bank[tg] = b; t_row[tg] = r; t_col[tg] = c; t_acc[tg] = acc;
    pend_tag[b] = tg;
    t_set[tg]++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(int tg);
    while (t_done[tg] < t_set[tg]) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures",
             d_checks + m_checks + 1, d_fails + m_fails + 1);
    $finish;
  end

  initial begin
    int a, t;
    int aa[4], ta[4];
    int a_a, t_a, a_b, t_b;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(req_ready == 1'b1, "R9 req_ready in reset", req_ready, 1);
    check(cmd_valid == 1'b0, "R9 cmd_valid in reset", cmd_valid, 0);
    check(rsp_valid == 1'b0, "R9 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && cmd_valid == 1'b0, "R9 idle after reset", cmd_valid, 0);

    // R2 closed bank
    send(0, 5, 1, a, t); wait_done(t);
    check(t_rd[t] - a == 2 + T_RCD, "R2 closed-bank read delay", t_rd[t] - a, 2 + T_RCD);
    // R3 row hit
    send(0, 5, 9, a, t); wait_done(t);
    check(t_rd[t] - a == 2, "R3 hit read delay", t_rd[t] - a, 2);
    // R4 row conflict
    send(0, 7, 2, a, t); wait_done(t);
    check(t_rd[t] - a == 2 + T_RP + T_RCD, "R4 conflict read delay", t_rd[t] - a, 2 + T_RP + T_RCD);
    // open distinct rows in banks 1..3
    for (int k = 1; k < 4; k++) begin
      send(k, 9 + k, 0, a, t); wait_done(t);
      check(t_rd[t] - a == 2 + T_RCD, "R2 opening read delay", t_rd[t] - a, 2 + T_RCD);
    end
    // R5/R6 back-to-back hits across banks
    send(0, 7, 3, aa[0], ta[0]);
    send(1, 10, 4, aa[1], ta[1]);
    send(2, 11, 5, aa[2], ta[2]);
    send(3, 12, 6, aa[3], ta[3]);
    for (int k = 0; k < 4; k++) wait_done(ta[k]);
    for (int k = 0; k < 4; k++) begin
      check(t_rd[ta[k]] - aa[k] == 2, "R5 open row kept per bank", t_rd[ta[k]] - aa[k], 2);
      check(t_rsp[ta[k]] == t_rsp[ta[0]] + k, "R6 consecutive responses",
            t_rsp[ta[k]] - t_rsp[ta[0]], k);
    end
    // R7 oldest wins a collision
    send(4, 1, 0, a, t); wait_done(t);
    send(4, 2, 0, a_a, t_a);
    @(negedge clk);
    @(negedge clk);
    send(5, 3, 0, a_b, t_b);
    check(a_b == a_a + 3, "R1 other bank accepted while one busy", a_b - a_a, 3);
    wait_done(t_a); wait_done(t_b);
    check(t_rd[t_a] - a_a == 2 + T_RP + T_RCD, "R7 older request on time",
          t_rd[t_a] - a_a, 2 + T_RP + T_RCD);
    check(t_rd[t_b] - a_b == 3 + T_RCD, "R7 younger request delayed one cycle",
          t_rd[t_b] - a_b, 3 + T_RCD);
    // R1 busy bank not ready, other bank ready
    send(6, 1, 0, a, t); wait_done(t);
    send(6, 2, 0, a, t);
    req_bank = 3'd6; #1;
    check(req_ready == 1'b0, "R1 busy bank ready", req_ready, 0);
    req_bank = 3'd7; #1;
    check(req_ready == 1'b1, "R1 free bank ready", req_ready, 1);
    wait_done(t);
    // random mix
    for (int n = 0; n < 80; n++) begin
      send(int'($urandom % NB), int'($urandom % 4), int'($urandom % 128), a, t);
      if ($urandom % 4 == 0) @(negedge clk);
    end
    for (int k = 0; k < 64; k++) wait_done(k);
    begin
      int s, d;
      s = 0; d = 0;
      for (int k = 0; k < 64; k++) begin s += t_set[k]; d += t_done[k]; end
      check(s == d, "R8 one response per request", d, s);
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures",
             d_checks + m_checks, d_fails + m_fails + wd_fail);
    $finish;
  end
endmodule